// File: doc/BRIEF.md
# Serial Port Interrupt Status, Mask and Clear Unit

This block gathers the interrupt sources of a serial peripheral's transmit and receive FIFOs and turns them into one interrupt line. Two sources track FIFO fill levels against programmable thresholds and follow the levels live. Three sources record error events: a push into a full transmit FIFO, a pop from an empty receive FIFO, and a received frame that arrives while the receive FIFO is full. Once set, each error source stays set until software clears it.

Software reaches the unit through a small register port. Writes are single-cycle and reads are combinational. Through this port it sets the two thresholds and a five-bit enable mask, reads the raw and the masked status, and writes a clear register. The clear register uses its own bit order and has a bit that clears everything. The FIFOs sit outside this unit and provide only their fill levels and their push, pop and frame-arrival strobes.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Status bit 0 is 1 exactly when `tx_level` is less than or equal to the transmit threshold. It follows the level in the same cycle and no clear write changes it.
- R2: Status bit 4 is 1 exactly when `rx_level` is greater than or equal to the receive threshold. It follows the level in the same cycle.
- R3: Status bit 1 (transmit overflow) becomes 1 in the cycle after `tx_push` is high while `tx_level` equals FIFO_DEPTH. It then stays 1 until cleared. A push below full does not set it.
- R4: Status bit 2 (receive underflow) becomes 1 in the cycle after `rx_pop` is high while `rx_level` is 0. It then stays 1 until cleared.
- R5: Status bit 3 (receive overflow) becomes 1 in the cycle after `rx_frame_in` is high while `rx_level` equals FIFO_DEPTH. It then stays 1 until cleared.
- R6: The masked status at address 4 equals the raw status at address 3 ANDed with the mask at address 2, bits [4:0].
- R7: `irq` is 1 exactly when at least one masked status bit is 1.
- R8: A write to the clear register at address 5 acts on the sticky bits as follows: data bit 3 clears status bit 1, data bit 1 clears status bit 2, and data bit 2 clears status bit 3. A read of address 5 returns 0.
- R9: Data bit 0 of a clear write clears all three sticky bits. Status bits 0 and 4 are not affected.
- R10: When an event sets a sticky bit in the same cycle that a clear write targets it, the bit ends up set.
- R11: After reset, both thresholds read 0, the mask reads 0, all sticky bits are 0 and `irq` is 0.
- R12: Address 0 holds the transmit threshold and address 1 holds the receive threshold. Writes to addresses 3 and 4 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_level | input | LVL_W | Entries held in the transmit FIFO |
| rx_level | input | LVL_W | Entries held in the receive FIFO |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| rx_pop | input | 1 | Read strobe from the receive FIFO |
| rx_frame_in | input | 1 | A received frame is being stored |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
An error event and a clear write that targets the same sticky bit can land in the same clock cycle. The bench provokes this by raising the event strobe on the same falling edge that starts the clear write, so that one rising edge captures both. It then reads the raw status and expects the bit to be set. A second case of the same kind pairs a clear-all write with a receive underflow. Here the underflow bit must survive, and the sticky bits that had no event must be cleared.

// File: rtl/spi_irq_pkg.sv
// Shared constants for the serial-port interrupt unit.
// Assumes: status and clear bit positions are visible to software and must not move.
package spi_irq_pkg;
    localparam int NUM_SRC    = 5;
    localparam int NUM_STICKY = 3;

    // Raw/masked status bit positions
    localparam int ST_TX_THR  = 0;
    localparam int ST_TX_OVF  = 1;
    localparam int ST_RX_UDF  = 2;
    localparam int ST_RX_OVF  = 3;
    localparam int ST_RX_THR  = 4;

    // Clear register bit positions
    localparam int CL_ALL     = 0;
    localparam int CL_RX_UDF  = 1;
    localparam int CL_RX_OVF  = 2;
    localparam int CL_TX_OVF  = 3;
    localparam int CL_W       = 4;

    // Sticky bank slot order
    localparam int SK_TX_OVF  = 0;
    localparam int SK_RX_UDF  = 1;
    localparam int SK_RX_OVF  = 2;

    typedef enum logic [2:0] {
        A_TX_THR = 3'd0,
        A_RX_THR = 3'd1,
        A_MASK   = 3'd2,
        A_RAW    = 3'd3,
        A_MSKD   = 3'd4,
        A_CLEAR  = 3'd5
    } irq_addr_e;
endpackage

// File: rtl/spi_irq_cfg_regs.sv
// Writable configuration of the interrupt unit: both thresholds and the mask.
// It also turns a write to the clear address into a one-cycle clear pulse.
// Assumes: DATA_W >= LVL_W and DATA_W >= NUM_SRC. Writes take effect at the next edge.
module spi_irq_cfg_regs
    import spi_irq_pkg::*;
#(
    parameter int LVL_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [LVL_W-1:0]  tx_thr_o,
    output logic [LVL_W-1:0]  rx_thr_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [CL_W-1:0]   clr_o
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:LVL_W];

    // Threshold and mask storage, loaded on an addressed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_o <= '0;
            rx_thr_o <= '0;
            mask_o   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_TX_THR: tx_thr_o <= reg_wdata[LVL_W-1:0];
                A_RX_THR: rx_thr_o <= reg_wdata[LVL_W-1:0];
                A_MASK:   mask_o   <= reg_wdata[NUM_SRC-1:0];
                default:  ;
            endcase
        end
    end

    // Clear pulse, present only in the cycle of the write
    always_comb begin
        clr_o = '0;
        if (reg_wr && reg_addr == A_CLEAR) clr_o = reg_wdata[CL_W-1:0];
    end

    // R6: a mask write shows up on the mask output one cycle later
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MASK) |=> (mask_o == $past(reg_wdata[NUM_SRC-1:0])));

    // R12: writes to the read-only status addresses keep the configuration
    a_r12_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_RAW || reg_addr == A_MSKD)) |=>
        ($stable(mask_o) && $stable(tx_thr_o) && $stable(rx_thr_o)));
endmodule

// File: rtl/spi_irq_event_detect.sv
// Works out the level-based threshold hits and the one-cycle error events
// from the FIFO levels and the push, pop and frame strobes.
// Assumes: levels run from 0 to FIFO_DEPTH; full means level == FIFO_DEPTH.
module spi_irq_event_detect #(
    parameter int FIFO_DEPTH = 32,
    parameter int LVL_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    input  logic             tx_push,
    input  logic             rx_pop,
    input  logic             rx_frame_in,
    output logic             tx_thr_hit,
    output logic             rx_thr_hit,
    output logic             ev_tx_ovf,
    output logic             ev_rx_udf,
    output logic             ev_rx_ovf
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    logic tx_full, rx_full, rx_empty;

    // FIFO state flags taken from the levels
    always_comb begin
        tx_full  = (tx_level == FULL_LVL);
        rx_full  = (rx_level == FULL_LVL);
        rx_empty = (rx_level == '0);
    end

    // Live threshold comparisons
    always_comb begin
        tx_thr_hit = (tx_level <= tx_thr);
        rx_thr_hit = (rx_level >= rx_thr);
    end

    // Error events, one cycle wide
    always_comb begin
        ev_tx_ovf = tx_push     && tx_full;
        ev_rx_udf = rx_pop      && rx_empty;
        ev_rx_ovf = rx_frame_in && rx_full;
    end

    // R1: an empty transmit FIFO is always at or below any threshold
    a_r1_tx_empty_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> tx_thr_hit);

    // R2: a zero receive threshold is always reached
    a_r2_rx_zero_thr: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_thr == '0) |-> rx_thr_hit);
endmodule

// File: rtl/spi_irq_sticky.sv
// A bank of sticky event bits. A set pulse wins over a clear in the same cycle.
// Assumes: set and clear vectors are already in bank slot order.
module spi_irq_sticky #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] q_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_bit
        // One sticky flag: set has priority, clear otherwise, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)        q_o[g] <= 1'b0;
            else if (set_i[g]) q_o[g] <= 1'b1;
            else if (clr_i[g]) q_o[g] <= 1'b0;
        end

        // R10: an event in the clear cycle leaves the bit set
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> q_o[g]);

        // R8: a clear with no event empties the bit
        a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !q_o[g]);

        // R3: without set or clear the bit holds
        a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[g] && !set_i[g]) |=> $stable(q_o[g]));
    end
endmodule

// File: rtl/spi_irq_ctrl.sv
// Top of the serial-port interrupt unit. It assembles the raw status from the
// live threshold bits and the sticky error bits, applies the mask, drives the
// interrupt line and serves the register read port.
// Assumes: DATA_W >= LVL_W and DATA_W >= 5; reads are combinational.
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int  FIFO_DEPTH = 32,
    parameter int  DATA_W     = 8,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_push,
    input  logic              rx_pop,
    input  logic              rx_frame_in,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [LVL_W-1:0]      tx_thr, rx_thr;
    logic [NUM_SRC-1:0]    mask_q;
    logic [CL_W-1:0]       clr_pulse;
    logic                  tx_thr_hit, rx_thr_hit;
    logic                  ev_tx_ovf, ev_rx_udf, ev_rx_ovf;
    logic [NUM_STICKY-1:0] sk_set, sk_clr, sk_q;
    logic [NUM_SRC-1:0]    raw_st, msk_st;

    spi_irq_cfg_regs #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .tx_thr_o(tx_thr), .rx_thr_o(rx_thr), .mask_o(mask_q), .clr_o(clr_pulse)
    );

    spi_irq_event_detect #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_push(tx_push), .rx_pop(rx_pop), .rx_frame_in(rx_frame_in),
        .tx_thr_hit(tx_thr_hit), .rx_thr_hit(rx_thr_hit),
        .ev_tx_ovf(ev_tx_ovf), .ev_rx_udf(ev_rx_udf), .ev_rx_ovf(ev_rx_ovf)
    );

    // Put set events and clear bits into bank slot order
    always_comb begin
        sk_set[SK_TX_OVF] = ev_tx_ovf;
        sk_set[SK_RX_UDF] = ev_rx_udf;
        sk_set[SK_RX_OVF] = ev_rx_ovf;
        sk_clr[SK_TX_OVF] = clr_pulse[CL_ALL] | clr_pulse[CL_TX_OVF];
        sk_clr[SK_RX_UDF] = clr_pulse[CL_ALL] | clr_pulse[CL_RX_UDF];
        sk_clr[SK_RX_OVF] = clr_pulse[CL_ALL] | clr_pulse[CL_RX_OVF];
    end

    spi_irq_sticky #(.NUM(NUM_STICKY)) u_sticky (
        .clk(clk), .rst_n(rst_n),
        .set_i(sk_set), .clr_i(sk_clr), .q_o(sk_q)
    );

    // Raw status in software bit order, then the mask
    always_comb begin
        raw_st            = '0;
        raw_st[ST_TX_THR] = tx_thr_hit;
        raw_st[ST_TX_OVF] = sk_q[SK_TX_OVF];
        raw_st[ST_RX_UDF] = sk_q[SK_RX_UDF];
        raw_st[ST_RX_OVF] = sk_q[SK_RX_OVF];
        raw_st[ST_RX_THR] = rx_thr_hit;
        msk_st            = raw_st & mask_q;
    end

    // Interrupt line: any enabled source
    always_comb irq = |msk_st;

    // Register read port
    always_comb begin
        case (reg_addr)
            A_TX_THR: reg_rdata = DATA_W'(tx_thr);
            A_RX_THR: reg_rdata = DATA_W'(rx_thr);
            A_MASK:   reg_rdata = DATA_W'(mask_q);
            A_RAW:    reg_rdata = DATA_W'(raw_st);
            A_MSKD:   reg_rdata = DATA_W'(msk_st);
            default:  reg_rdata = '0;
        endcase
    end

    // R7: with every source disabled there is no interrupt
    a_r7_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R9: a clear-all write with no event leaves no sticky bit set
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLEAR && reg_wdata[CL_ALL] && !ev_tx_ovf && !ev_rx_udf && !ev_rx_ovf)
        |=> (sk_q == '0));

    // R3: a push into a full transmit FIFO is recorded
    a_r3_tx_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_level == LVL_W'(FIFO_DEPTH)) |=> sk_q[SK_TX_OVF]);
endmodule

// File: tb/test_spi_irq_ctrl.sv
module test_spi_irq_ctrl;
    localparam int DEPTH = 32;
    localparam int DW    = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [LW-1:0] tx_level, rx_level;
    logic          tx_push, rx_pop, rx_frame_in;
    logic [2:0]    reg_addr;
    logic          reg_wr;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int txthr_m = 0, rxthr_m = 0;
    logic [2:0] st_m = '0;   // {rx overflow, rx underflow, tx overflow}

    spi_irq_ctrl #(.FIFO_DEPTH(DEPTH), .DATA_W(DW)) i_spi_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .tx_push(tx_push), .rx_pop(rx_pop), .rx_frame_in(rx_frame_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_raw();
        return {(int'(rx_level) >= rxthr_m), st_m[2], st_m[1], st_m[0], (int'(tx_level) <= txthr_m)};
    endfunction

    task automatic write_reg(logic [2:0] a, logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(logic [2:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_raw(string req);
        logic [DW-1:0] d;
        read_reg(3'd3, d);
        check(req, d, DW'(exp_raw()));
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        tx_push = (which == 0); rx_pop = (which == 1); rx_frame_in = (which == 2);
        @(negedge clk);
        tx_push = 0; rx_pop = 0; rx_frame_in = 0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        read_reg(3'd0, d); check("R11 tx thr", d, 0);
        read_reg(3'd1, d); check("R11 rx thr", d, 0);
        read_reg(3'd2, d); check("R11 mask", d, 0);
        read_reg(3'd3, d); check("R11 raw", d, 8'h11);
        read_reg(3'd4, d); check("R11 masked", d, 0);
        check("R11 irq", irq, 0);
    endtask

    task automatic t_tx_threshold();
        logic [DW-1:0] d;
        write_reg(3'd0, 8'd4); txthr_m = 4;
        read_reg(3'd0, d); check("R12 tx thr addr0", d, 4);
        tx_level = 4; check_raw("R1 level equal");
        tx_level = 5; check_raw("R1 level above");
        tx_level = 3; write_reg(3'd5, 8'h01);
        check_raw("R9 clear-all keeps tx thr bit");
    endtask

    task automatic t_rx_threshold();
        logic [DW-1:0] d;
        write_reg(3'd1, 8'd8); rxthr_m = 8;
        read_reg(3'd1, d); check("R12 rx thr addr1", d, 8);
        rx_level = 7; check_raw("R2 below");
        rx_level = 8; check_raw("R2 equal");
        rx_level = 9; check_raw("R2 above");
    endtask

    task automatic t_tx_overflow();
        tx_level = DEPTH - 1; pulse(0); check_raw("R3 push below full");
        tx_level = DEPTH; pulse(0); st_m[0] = 1; check_raw("R3 push at full");
        tx_level = 0; @(negedge clk); check_raw("R3 sticky after drain");
    endtask

    task automatic t_rx_underflow();
        rx_level = 1; pulse(1); check_raw("R4 pop non-empty");
        rx_level = 0; pulse(1); st_m[1] = 1; check_raw("R4 pop empty");
        rx_level = 3; @(negedge clk); check_raw("R4 sticky");
    endtask

    task automatic t_rx_overflow();
        rx_level = DEPTH - 1; pulse(2); check_raw("R5 frame below full");
        rx_level = DEPTH; pulse(2); st_m[2] = 1; check_raw("R5 frame at full");
        rx_level = 5; @(negedge clk); check_raw("R5 sticky");
    endtask

    task automatic t_clear_map();
        logic [DW-1:0] d;
        write_reg(3'd5, 8'h02); st_m[1] = 0; check_raw("R8 clr bit1 -> underflow");
        write_reg(3'd5, 8'h08); st_m[0] = 0; check_raw("R8 clr bit3 -> tx overflow");
        write_reg(3'd5, 8'h04); st_m[2] = 0; check_raw("R8 clr bit2 -> rx overflow");
        read_reg(3'd5, d); check("R8 clear reads zero", d, 0);
        tx_level = DEPTH; pulse(0); rx_level = 0; pulse(1); rx_level = DEPTH; pulse(2);
        st_m = 3'b111; check_raw("R9 all set");
        write_reg(3'd5, 8'h01); st_m = 0; check_raw("R9 clear all");
    endtask

    task automatic t_mask_irq();
        logic [DW-1:0] d;
        tx_level = DEPTH; pulse(0); st_m[0] = 1;
        tx_level = 10; rx_level = 0;
        check_raw("R6 raw before mask");
        check("R7 irq masked off", irq, 0);
        write_reg(3'd2, 8'h02);
        read_reg(3'd4, d); check("R6 masked one bit", d, 8'h02);
        check("R7 irq on", irq, 1);
        write_reg(3'd2, 8'h1D);
        read_reg(3'd4, d); check("R6 masked other bits", d, 8'h00);
        check("R7 irq off", irq, 0);
        rx_level = 9;
        read_reg(3'd4, d); check("R6 rx thr enabled", d, 8'h10);
        check("R7 irq from rx thr", irq, 1);
        rx_level = 0;
        write_reg(3'd3, 8'hFF); write_reg(3'd4, 8'h00);
        read_reg(3'd2, d); check("R12 mask unchanged", d, 8'h1D);
        check_raw("R12 raw unchanged");
        write_reg(3'd5, 8'h01); st_m = 0;
    endtask

    task automatic t_set_clear_same();
        tx_level = DEPTH;
        @(negedge clk);
        reg_addr = 3'd5; reg_wdata = 8'h08; reg_wr = 1; tx_push = 1;
        @(negedge clk);
        reg_wr = 0; tx_push = 0; st_m[0] = 1;
        tx_level = 0;
        check_raw("R10 set beats clear");
        rx_level = DEPTH; pulse(2); st_m[2] = 1;
        rx_level = 0;
        @(negedge clk);
        reg_addr = 3'd5; reg_wdata = 8'h01; reg_wr = 1; rx_pop = 1;
        @(negedge clk);
        reg_wr = 0; rx_pop = 0; st_m = 3'b010;
        check_raw("R10 clear-all with underflow");
    endtask

    initial begin
        rst_n = 0; tx_level = 0; rx_level = 0;
        tx_push = 0; rx_pop = 0; rx_frame_in = 0;
        reg_addr = 0; reg_wr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx_threshold();
        t_rx_threshold();
        t_tx_overflow();
        t_rx_underflow();
        t_rx_overflow();
        t_clear_map();
        t_mask_irq();
        t_set_clear_same();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule